// File: doc/BRIEF.md
# Two-Wire Register Target for a Voltage Regulator

This block is the serial control port of a programmable step-down regulator. It follows an I2C bus (SCL as input, SDA as an open-drain line), recognises START, repeated START and STOP, and answers a fixed 7-bit target address. A write transfer loads a register pointer and then one data byte. A read transfer loads the pointer, turns the bus round with a repeated START and returns one byte.

Behind the port sits a six-entry register bank: two setpoint registers (rail enable, forced-PWM flag, 6-bit voltage code), a control register (discharge enable, 3-bit ramp-rate code, a self-clearing soft-reset bit), two fixed identification bytes and a status byte that carries a power-good input. The high-speed master code is recognised, not acknowledged, and marks high-speed operation until the next STOP. While the hardware enable input is low the port is inert and every register sits at its default.

SCL and SDA are brought into the system clock domain through a synchroniser chain, and all bus decoding works on edges of the synchronised lines. The system clock must run at least 8 times the SCL rate.

Top module: `vreg_i2c_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal 7'b1100000 (byte 0xC0 for write, 0xC1 for read) and never pulls SDA low for any other address byte.
- R2: A write transfer (START, 0xC0, pointer, data, STOP) acknowledges all three bytes and stores the data in the addressed writable register; setpoint addresses are 0x00 (A) and 0x01 (B), control is 0x02.
- R3: A read transfer (START, 0xC0, pointer, repeated START, 0xC1, data, master NACK, STOP) returns the addressed register MSB first.
- R4: A first byte of the form 5'b00001 in bits 7:3 after a START is not acknowledged and raises hs_o; hs_o stays high across repeated STARTs and falls at STOP.
- R5: After reset, setpoint A is 0x28, setpoint B is 0xAC (bit 7 rail enable, bit 6 forced PWM, bits 5:0 voltage code) and control is 0x80.
- R6: Control bit 7 is discharge enable and bits 6:4 are the ramp code; bits 3, 1 and 0 always read 0; writing 1 to bit 2 returns every register to its default and bit 2 reads 0.
- R7: Address 0x03 reads 0x80, address 0x04 reads 0x01 and address 0x05 reads {pgood_i, 7'b0}.
- R8: Writes to addresses 0x03 to 0xFF are acknowledged and change nothing; reads of 0x06 to 0xFF return 0x00.
- R9: While chip_en is low, all registers hold their defaults, SDA is released, hs_o is low and no transfer is acknowledged.
- R10: SDA is driven only in acknowledge slots and read-data bits; it is released during address, pointer and write-data bits and after a read completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Hardware enable; low forces defaults and idles the port |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| pgood_i | input | 1 | Power-good flag reported in the status byte |
| setpt_a_o | output | 8 | Setpoint A register |
| setpt_b_o | output | 8 | Setpoint B register |
| ctrl_o | output | 8 | Control register as read back |
| hs_o | output | 1 | High-speed operation active |

## Verification
Each SCL or SDA edge reaches the decoder after the synchroniser stages plus one edge-detect flop, so the acknowledge or read bit appears on SDA about four system clocks after the SCL falling edge, and a register output changes one clock after the eighth rising edge of the data byte. The bench splits each SCL period into four quarters of four clocks, moves SDA one quarter after SCL falls and samples the line three quarters after that fall, well after the design's response is due. Register outputs and hs_o are checked only after the STOP or the enable change has had several quarters to settle.

// File: rtl/vreg_i2c_pkg.sv
package vreg_i2c_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_SETPT = 2;
    localparam int SEL_W     = (NUM_SETPT > 1) ? $clog2(NUM_SETPT) : 1;

    localparam logic [BYTE_W-1:0] REG_CTRL = 8'h02;
    localparam logic [BYTE_W-1:0] REG_ID_A = 8'h03;
    localparam logic [BYTE_W-1:0] REG_ID_B = 8'h04;
    localparam logic [BYTE_W-1:0] REG_STAT = 8'h05;

    localparam logic [BYTE_W-1:0] ID_A_VAL = 8'h80;
    localparam logic [BYTE_W-1:0] ID_B_VAL = 8'h01;

    localparam int          CTRL_RST_BIT = 2;
    localparam logic [4:0]  HS_CODE_HI   = 5'b00001;

    typedef struct packed {
        logic       rail_on;
        logic       pwm_force;
        logic [5:0] code;
    } setpt_t;

    typedef struct packed {
        logic       discharge;
        logic [2:0] slew;
    } ctrl_t;

    localparam ctrl_t CTRL_DEF = '{discharge: 1'b1, slew: 3'b000};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDAT,
        ST_ACK,
        ST_RDAT,
        ST_RACK,
        ST_SKIP
    } eng_state_t;

    function automatic setpt_t setpt_default(int unsigned idx);
        return (idx == 0) ? setpt_t'(8'h28) : setpt_t'(8'hAC);
    endfunction

    function automatic logic [BYTE_W-1:0] ctrl_to_byte(ctrl_t c);
        return {c.discharge, c.slew, 4'b0000};
    endfunction

    function automatic logic is_hs_code(logic [BYTE_W-1:0] b);
        return b[7:3] == HS_CODE_HI;
    endfunction

endpackage

// File: rtl/vreg_bus_frontend.sv
module vreg_bus_frontend #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int LINES = 2;

    logic [STAGES-1:0][LINES-1:0] chain;
    logic scl_s, scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], {scl_i, sda_i}};
        end
    end

    assign scl_s = chain[STAGES-1][1];
    assign sda_s = chain[STAGES-1][0];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/vreg_proto_engine.sv
module vreg_proto_engine
    import vreg_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic              hs_o,
    output logic [BYTE_W-1:0] ptr_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output eng_state_t        state_o
);
    eng_state_t        state, ack_next;
    logic [2:0]        bitcnt;
    logic [BYTE_W-2:0] shreg;
    logic [BYTE_W-2:0] txsh;
    logic [BYTE_W-1:0] rx;
    logic              byte_end;
    logic              ack_on;

    assign rx       = {shreg, sda_s};
    assign byte_end = scl_rise && (bitcnt == 3'd7);

    assign wr_en_o   = en_i && !start_ev && !stop_ev && (state == ST_WDAT) && byte_end;
    assign wr_data_o = rx;
    assign state_o   = state;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            state    <= ST_IDLE;
            ack_next <= ST_SKIP;
            bitcnt   <= '0;
            shreg    <= '0;
            txsh     <= '0;
            sda_oe_o <= 1'b0;
            ack_on   <= 1'b0;
            hs_o     <= 1'b0;
            ptr_o    <= '0;
        end else if (stop_ev) begin
            state    <= ST_IDLE;
            sda_oe_o <= 1'b0;
            ack_on   <= 1'b0;
            hs_o     <= 1'b0;
        end else if (start_ev) begin
            state    <= ST_ADDR;
            bitcnt   <= '0;
            sda_oe_o <= 1'b0;
            ack_on   <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_PTR, ST_WDAT: begin
                    if (scl_rise) begin
                        shreg  <= rx[BYTE_W-2:0];
                        bitcnt <= bitcnt + 3'd1;
                    end
                    if (byte_end) begin
                        if (state == ST_ADDR) begin
                            if (!hs_o && is_hs_code(rx)) begin
                                hs_o  <= 1'b1;
                                state <= ST_SKIP;
                            end else if (rx[7:1] == DEV_ADDR) begin
                                state    <= ST_ACK;
                                ack_next <= rx[0] ? ST_RDAT : ST_PTR;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end else if (state == ST_PTR) begin
                            ptr_o    <= rx;
                            state    <= ST_ACK;
                            ack_next <= ST_WDAT;
                        end else begin
                            state    <= ST_ACK;
                            ack_next <= ST_SKIP;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (!ack_on) begin
                            ack_on   <= 1'b1;
                            sda_oe_o <= 1'b1;
                        end else begin
                            ack_on <= 1'b0;
                            bitcnt <= '0;
                            state  <= ack_next;
                            if (ack_next == ST_RDAT) begin
                                txsh     <= rd_data_i[BYTE_W-2:0];
                                sda_oe_o <= ~rd_data_i[BYTE_W-1];
                            end else begin
                                sda_oe_o <= 1'b0;
                            end
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) begin
                            state <= ST_RACK;
                        end
                    end else if (scl_fall) begin
                        sda_oe_o <= ~txsh[BYTE_W-2];
                        txsh     <= {txsh[BYTE_W-3:0], 1'b0};
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        sda_oe_o <= 1'b0;
                        state    <= ST_SKIP;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/vreg_reg_bank.sv
module vreg_reg_bank
    import vreg_i2c_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             en_i,
    input  logic                             wr_en_i,
    input  logic [BYTE_W-1:0]                wr_addr_i,
    input  logic [BYTE_W-1:0]                wr_data_i,
    input  logic [BYTE_W-1:0]                rd_addr_i,
    input  logic                             pgood_i,
    output logic [BYTE_W-1:0]                rd_data_o,
    output logic [NUM_SETPT-1:0][BYTE_W-1:0] setpt_o,
    output logic [BYTE_W-1:0]                ctrl_o
);
    logic  soft_rst;
    logic  to_default;
    ctrl_t ctrl_q;

    assign soft_rst   = wr_en_i && (wr_addr_i == REG_CTRL) && wr_data_i[CTRL_RST_BIT];
    assign to_default = rst || !en_i || soft_rst;

    for (genvar i = 0; i < NUM_SETPT; i++) begin : g_setpt
        localparam logic [BYTE_W-1:0] MY_ADDR = BYTE_W'(i);
        setpt_t q;
        always_ff @(posedge clk) begin
            if (to_default) begin
                q <= setpt_default(i);
            end else if (wr_en_i && (wr_addr_i == MY_ADDR)) begin
                q <= setpt_t'(wr_data_i);
            end
        end
        assign setpt_o[i] = q;
    end

    always_ff @(posedge clk) begin
        if (to_default) begin
            ctrl_q <= CTRL_DEF;
        end else if (wr_en_i && (wr_addr_i == REG_CTRL)) begin
            ctrl_q <= ctrl_t'(wr_data_i[7:4]);
        end
    end

    assign ctrl_o = ctrl_to_byte(ctrl_q);

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i < BYTE_W'(NUM_SETPT)) begin
            rd_data_o = setpt_o[rd_addr_i[SEL_W-1:0]];
        end else begin
            unique case (rd_addr_i)
                REG_CTRL: rd_data_o = ctrl_o;
                REG_ID_A: rd_data_o = ID_A_VAL;
                REG_ID_B: rd_data_o = ID_B_VAL;
                REG_STAT: rd_data_o = {pgood_i, 7'b0000000};
                default:  rd_data_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/vreg_i2c_target.sv
module vreg_i2c_target
    import vreg_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h60,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              pgood_i,
    output logic [BYTE_W-1:0] setpt_a_o,
    output logic [BYTE_W-1:0] setpt_b_o,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic              hs_o
);
    logic                             sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [BYTE_W-1:0]                ptr, rd_data, wr_data;
    logic                             wr_en;
    logic [NUM_SETPT-1:0][BYTE_W-1:0] setpt;
    eng_state_t                       eng_state;

    vreg_bus_frontend #(.STAGES(SYNC_STAGES)) u_front (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    vreg_proto_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .en_i      (chip_en),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .rd_data_i (rd_data),
        .sda_oe_o  (sda_oe),
        .hs_o      (hs_o),
        .ptr_o     (ptr),
        .wr_en_o   (wr_en),
        .wr_data_o (wr_data),
        .state_o   (eng_state)
    );

    vreg_reg_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .en_i      (chip_en),
        .wr_en_i   (wr_en),
        .wr_addr_i (ptr),
        .wr_data_i (wr_data),
        .rd_addr_i (ptr),
        .pgood_i   (pgood_i),
        .rd_data_o (rd_data),
        .setpt_o   (setpt),
        .ctrl_o    (ctrl_o)
    );

    assign setpt_a_o = setpt[0];
    assign setpt_b_o = setpt[1];

endmodule

// File: rtl/vreg_i2c_target_chk.sv
module vreg_i2c_target_chk
    import vreg_i2c_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       chip_en,
    input logic       sda_oe,
    input logic       hs_o,
    input logic [7:0] setpt_a_o,
    input logic [7:0] setpt_b_o,
    input logic [7:0] ctrl_o,
    input logic       wr_en,
    input eng_state_t eng_state
);
    p_release_off_r9: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> !sda_oe);

    p_defaults_off_r9: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> (setpt_a_o == 8'h28 && setpt_b_o == 8'hAC && ctrl_o == 8'h80));

    p_hs_clear_off_r4: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> !hs_o);

    p_drive_slot_r10: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (eng_state == ST_ACK || eng_state == ST_RDAT || eng_state == ST_RACK));

    p_hold_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        (chip_en && !wr_en) |=> ($stable(setpt_a_o) && $stable(setpt_b_o) && $stable(ctrl_o)));

endmodule

bind vreg_i2c_target vreg_i2c_target_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .chip_en   (chip_en),
    .sda_oe    (sda_oe),
    .hs_o      (hs_o),
    .setpt_a_o (setpt_a_o),
    .setpt_b_o (setpt_b_o),
    .ctrl_o    (ctrl_o),
    .wr_en     (wr_en),
    .eng_state (eng_state)
);

// File: tb/vreg_i2c_target_tb_top.sv
module vreg_i2c_target_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chip_en = 1'b1;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic pgood = 1'b0;
    logic sda_oe, hs_o;
    logic [7:0] setpt_a, setpt_b, ctrl;
    wire  sda_line = m_sda & ~sda_oe;

    int n_checks = 0;
    int n_fail   = 0;
    int stray    = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vreg_i2c_target dut_i (
        .clk       (clk),
        .rst       (rst),
        .chip_en   (chip_en),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .pgood_i   (pgood),
        .setpt_a_o (setpt_a),
        .setpt_b_o (setpt_b),
        .ctrl_o    (ctrl),
        .hs_o      (hs_o)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        m_sda = 1'b0; tick(Q);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); m_sda = 1'b0;
        tick(Q); scl = 1'b1;
        tick(Q); m_sda = 1'b1;
        tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            tick(Q); m_sda = b[i];
            tick(Q); scl = 1'b1;
            tick(Q); if (sda_oe) stray++;
            tick(Q); scl = 1'b0;
        end
        tick(Q); m_sda = 1'b1;
        tick(Q); scl = 1'b1;
        tick(Q); ack = sda_line;
        tick(Q); scl = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic nack);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(2*Q); scl = 1'b1;
            tick(Q);   b[i] = sda_line;
            tick(Q);   scl = 1'b0;
        end
        tick(Q); m_sda = nack;
        tick(Q); scl = 1'b1;
        tick(2*Q); scl = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, output logic ok);
        logic k0, k1, k2;
        bus_start();
        send_byte(8'hC0, k0);
        send_byte(a, k1);
        send_byte(d, k2);
        bus_stop();
        ok = !k0 && !k1 && !k2;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d, output logic ok);
        logic k0, k1, k2;
        bus_start();
        send_byte(8'hC0, k0);
        send_byte(a, k1);
        bus_start();
        send_byte(8'hC1, k2);
        recv_byte(d, 1'b1);
        bus_stop();
        ok = !k0 && !k1 && !k2;
    endtask

    task automatic t_reset();
        chk("R5 setpt A default", setpt_a, 8'h28);
        chk("R5 setpt B default", setpt_b, 8'hAC);
        chk("R5 ctrl default", ctrl, 8'h80);
        chk("R10 idle release", {7'b0, sda_oe}, 8'h00);
        chk("R4 hs low at reset", {7'b0, hs_o}, 8'h00);
    endtask

    task automatic t_write_read();
        logic ok; logic [7:0] d;
        wr_reg(8'h00, 8'h5A, ok);
        chk("R2 write acks", {7'b0, ok}, 8'h01);
        chk("R2 setpt A written", setpt_a, 8'h5A);
        rd_reg(8'h00, d, ok);
        chk("R3 read acks", {7'b0, ok}, 8'h01);
        chk("R3 read setpt A", d, 8'h5A);
        rd_reg(8'h01, d, ok);
        chk("R3 read setpt B", d, 8'hAC);
        chk("R10 released after read", {7'b0, sda_oe}, 8'h00);
        wr_reg(8'h01, 8'hC3, ok);
        chk("R2 setpt B written", setpt_b, 8'hC3);
    endtask

    task automatic t_wrong_addr();
        logic k;
        bus_start();
        send_byte(8'h90, k);
        send_byte(8'h00, k);
        bus_stop();
        chk("R1 foreign address nack", {7'b0, k}, 8'h01);
        bus_start();
        send_byte(8'hC2, k);
        bus_stop();
        chk("R1 near address nack", {7'b0, k}, 8'h01);
        chk("R1 no change", setpt_a, 8'h5A);
    endtask

    task automatic t_ids();
        logic ok; logic [7:0] d;
        rd_reg(8'h03, d, ok); chk("R7 id A", d, 8'h80);
        rd_reg(8'h04, d, ok); chk("R7 id B", d, 8'h01);
        pgood = 1'b1; tick(Q);
        rd_reg(8'h05, d, ok); chk("R7 status pgood 1", d, 8'h80);
        pgood = 1'b0; tick(Q);
        rd_reg(8'h05, d, ok); chk("R7 status pgood 0", d, 8'h00);
    endtask

    task automatic t_ctrl();
        logic ok; logic [7:0] d;
        wr_reg(8'h02, 8'h7B, ok);
        chk("R6 ctrl reserved bits dropped", ctrl, 8'h70);
        rd_reg(8'h02, d, ok);
        chk("R6 ctrl read", d, 8'h70);
        wr_reg(8'h00, 8'h3F, ok);
        wr_reg(8'h02, 8'h74, ok);
        chk("R6 soft reset acked", {7'b0, ok}, 8'h01);
        chk("R6 soft reset setpt A", setpt_a, 8'h28);
        chk("R6 soft reset setpt B", setpt_b, 8'hAC);
        chk("R6 soft reset ctrl", ctrl, 8'h80);
        rd_reg(8'h02, d, ok);
        chk("R6 reset bit reads 0", d, 8'h80);
    endtask

    task automatic t_readonly();
        logic ok; logic [7:0] d;
        wr_reg(8'h00, 8'h12, ok);
        wr_reg(8'h03, 8'hFF, ok);
        chk("R8 write id acked", {7'b0, ok}, 8'h01);
        rd_reg(8'h03, d, ok);
        chk("R8 id unchanged", d, 8'h80);
        wr_reg(8'h10, 8'h55, ok);
        chk("R8 unmapped write acked", {7'b0, ok}, 8'h01);
        chk("R8 setpt A untouched", setpt_a, 8'h12);
        chk("R8 ctrl untouched", ctrl, 8'h80);
        rd_reg(8'h10, d, ok);
        chk("R8 unmapped read 0x10", d, 8'h00);
        rd_reg(8'h06, d, ok);
        chk("R8 unmapped read 0x06", d, 8'h00);
    endtask

    task automatic t_hs();
        logic k0, k1, k2, k3;
        bus_start();
        send_byte(8'h0A, k0);
        chk("R4 master code not acked", {7'b0, k0}, 8'h01);
        chk("R4 hs raised", {7'b0, hs_o}, 8'h01);
        bus_start();
        send_byte(8'hC0, k1);
        send_byte(8'h01, k2);
        send_byte(8'h11, k3);
        chk("R4 hs kept over repeated start", {7'b0, hs_o}, 8'h01);
        chk("R4 hs transfer acked", {5'b0, k1, k2, k3}, 8'h00);
        bus_stop();
        chk("R4 hs cleared at stop", {7'b0, hs_o}, 8'h00);
        chk("R4 hs write landed", setpt_b, 8'h11);
    endtask

    task automatic t_enable();
        logic ok, k;
        wr_reg(8'h00, 8'h33, ok);
        bus_start();
        send_byte(8'h0B, k);
        chip_en = 1'b0; tick(Q);
        chk("R9 defaults while off A", setpt_a, 8'h28);
        chk("R9 defaults while off B", setpt_b, 8'hAC);
        chk("R9 hs low while off", {7'b0, hs_o}, 8'h00);
        bus_stop();
        bus_start();
        send_byte(8'hC0, k);
        bus_stop();
        chk("R9 no ack while off", {7'b0, k}, 8'h01);
        chk("R9 released while off", {7'b0, sda_oe}, 8'h00);
        chip_en = 1'b1; tick(Q);
        chk("R9 defaults after enable", setpt_a, 8'h28);
        wr_reg(8'h00, 8'h44, ok);
        chk("R9 works again", setpt_a, 8'h44);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(5);
        t_reset();
        t_write_read();
        t_wrong_addr();
        t_ids();
        t_ctrl();
        t_readonly();
        t_hs();
        t_enable();
        chk("R10 no drive in host bits", stray[7:0], 8'h00);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule